// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block sits behind the SPI front end of a serial byte-addressed nonvolatile memory. It holds the device status byte: a write-enable latch, a two-bit block-protect field and a hardware-protect enable bit. It makes every write-permission decision for the memory. The front end sends it set-latch and clear-latch pulses, status-write requests with their data byte, the chip-select level and the address being programmed. The page-write engine reports its busy level.

The block drives three outputs. The first is the status byte the front end shifts out on a status read. The second flags whether the current address lies in a block-protected range. The third says whether a status write would be accepted now. The hardware-protect pin is active low. It locks the status register only while the protect-enable bit is set.

An accepted status write does not take effect at once. It waits for chip select to rise, then runs a timed internal cycle of `WR_CYCLES` clocks. During that cycle the status byte reads as all ones. The new protect bits are applied when the cycle ends, and the write-enable latch then drops. The protect bits are plain registers with a parameterised reset value.

Top module: `sreg_guard`

## Requirements
- R1: Outside a write cycle, `status_o` is `{wpen, 3'b000, bp1, bp0, wel, 1'b0}`: bit 7 is protect-enable, bits 3:2 are the block-protect field, bit 1 is the write-enable latch and bit 0 is the ready flag (0 = idle). After reset, with default parameters, it reads 0x00.
- R2: While `busy_i` is high, or while an internal status-write cycle runs, `status_o` reads 0xFF.
- R3: For a 14-bit address, `addr_prot_o` depends on the block-protect field as follows: 00 protects no address, 01 protects 0x3000–0x3FFF, 10 protects 0x2000–0x3FFF and 11 protects every address.
- R4: A `wren_i` pulse sets the write-enable latch. A `wrdi_i` pulse clears it whatever the level of `wp_ni`. When both pulses arrive in the same cycle, the latch is cleared.
- R5: `sr_wr_ok_o` is high only when all of these hold: the latch is set, the block is not busy, and hardware protection (`wp_ni` low with protect-enable 1) is inactive.
- R6: A status-write request made while `sr_wr_ok_o` is low is dropped. No cycle starts and the status byte does not change.
- R7: An accepted status write starts its cycle at the first clock that sees `cs_ni` high. It changes only bits 7, 3 and 2; data bits 6:4 and 1:0 are ignored. The new value appears exactly `WR_CYCLES` clocks after the start.
- R8: If hardware protection becomes active before `cs_ni` rises, the pending status write is cancelled and no cycle runs. Once the cycle has started, `wp_ni` has no effect on it.
- R9: The write-enable latch clears when a write cycle ends: either `busy_i` falls, or an internal status-write cycle completes.
- R10: A status-write request that arrives while `busy_i` is high is dropped. No cycle follows when busy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select level from the serial pins, active low |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| wren_i | input | 1 | One-cycle pulse: set write-enable latch |
| wrdi_i | input | 1 | One-cycle pulse: clear write-enable latch |
| sr_wr_req_i | input | 1 | One-cycle pulse: status write byte received |
| sr_wr_data_i | input | 8 | Status write data byte |
| busy_i | input | 1 | Page-write engine busy level |
| addr_i | input | ADDR_W | Array byte address to check |
| status_o | output | 8 | Status byte for status reads |
| addr_prot_o | output | 1 | `addr_i` falls in a block-protected range |
| sr_wr_ok_o | output | 1 | A status write would be accepted now |

## Verification
The assertions check four things on every cycle. The protect bits change only at the end of a status cycle. The latch rises only after an accepted set pulse and falls at each write-cycle end. The internal cycle starts only from a pending write. The range decoder keeps its fixed end cases. Only the bench's scenarios can show three further behaviours. One is the exact clock at which new protect bits appear, including the masking of unused data bits. Another is the cancel window, where the protect pin acts before chip select rises but not after the cycle starts. The last is that requests made while busy or while not permitted leave no trace in the status byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned SR_W = 8;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } sr_cfg_t;

  function automatic logic [SR_W-1:0] pack_status(sr_cfg_t cfg, logic wel, logic busy);
    if (busy) return '1;
    return {cfg.wpen, 3'b000, cfg.bp, wel, 1'b0};
  endfunction

  function automatic sr_cfg_t unpack_cfg(logic [SR_W-1:0] d);
    sr_cfg_t c;
    c.wpen = d[7];
    c.bp   = d[3:2];
    return c;
  endfunction
endpackage

// File: rtl/bp_range_dec.sv
module bp_range_dec (
  input  logic [1:0] bp_i,
  input  logic [1:0] top_i,
  output logic       prot_o
);
  logic [1:0] thr;

  always_comb begin
    unique case (bp_i)
      2'b01:   thr = 2'b11;
      2'b10:   thr = 2'b10;
      default: thr = 2'b00;
    endcase
    prot_o = (bp_i != 2'b00) && (top_i >= thr);
  end

  always_comb begin
    // R3
    if (bp_i == 2'b00) begin
      bp_none_chk: assert (!prot_o);
    end
    // R3
    if (bp_i == 2'b11) begin
      bp_all_chk: assert (prot_o);
    end
  end
endmodule

// File: rtl/wr_cycle_timer.sv
module wr_cycle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  // R7
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned WR_CYCLES = 16,
  parameter logic [1:0]  RST_BP    = 2'b00,
  parameter logic        RST_WPEN  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_req_i,
  input  logic [SR_W-1:0]   sr_wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SR_W-1:0]   status_o,
  output logic              addr_prot_o,
  output logic              sr_wr_ok_o
);
  sr_cfg_t cfg_q, pend_q;
  logic    wel_q, pend_vld_q, cs_q, busy_q;
  logic    hw_prot, busy_all, cs_rise, tmr_start, tmr_busy, tmr_done, cyc_end;

  logic unused_bits;
  assign unused_bits = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0], addr_i[ADDR_W-3:0]};

  assign hw_prot    = !wp_ni && cfg_q.wpen;
  assign busy_all   = busy_i || tmr_busy;
  assign sr_wr_ok_o = wel_q && !hw_prot && !busy_all;
  assign cs_rise    = cs_ni && !cs_q;
  assign tmr_start  = cs_rise && pend_vld_q && !hw_prot && !busy_all;
  assign cyc_end    = tmr_done || (busy_q && !busy_i);

  wr_cycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .busy_o  (tmr_busy),
    .done_o  (tmr_done)
  );

  bp_range_dec u_dec (
    .bp_i   (cfg_q.bp),
    .top_i  (addr_i[ADDR_W-1 -: 2]),
    .prot_o (addr_prot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      busy_q <= busy_i;
    end
  end

  // write-enable latch: cycle end and disable take priority over enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wel_q <= 1'b0;
    else if (cyc_end)               wel_q <= 1'b0;
    else if (!busy_all && wrdi_i)   wel_q <= 1'b0;
    else if (!busy_all && wren_i)   wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (tmr_start || hw_prot) begin
      pend_vld_q <= 1'b0;
    end else if (sr_wr_req_i && sr_wr_ok_o) begin
      pend_vld_q <= 1'b1;
      pend_q     <= unpack_cfg(sr_wr_data_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.wpen <= RST_WPEN;
      cfg_q.bp   <= RST_BP;
    end else if (tmr_done) begin
      cfg_q <= pend_q;
    end
  end

  assign status_o = pack_status(cfg_q, wel_q, busy_all);

  // R7
  cfg_commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(tmr_done));
  // R4
  wel_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(wren_i && !wrdi_i && !busy_all));
  // R9
  wel_clear_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_done || $fell(busy_i)) |=> !wel_q);
  // R8
  start_from_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_busy) |-> $past(pend_vld_q));
endmodule

// File: tb/sreg_guard_tb.sv
module sreg_guard_tb_top;
  localparam int unsigned AW = 14;
  localparam int unsigned W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, req = 1'b0, busy = 1'b0;
  logic [7:0] wdata = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic prot, ok;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      rid;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  sreg_guard #(.ADDR_W(AW), .WR_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wp_ni(wp_n),
    .wren_i(wren), .wrdi_i(wrdi), .sr_wr_req_i(req), .sr_wr_data_i(wdata),
    .busy_i(busy), .addr_i(addr), .status_o(status),
    .addr_prot_o(prot), .sr_wr_ok_o(ok)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = status;
        1:       act = {7'd0, prot};
        default: act = {7'd0, ok};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.rid, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [7:0] exp, string rid);
    item_t it;
    it.kind = kind; it.exp = exp; it.rid = rid;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_wren(); wren = 1; step(); wren = 0; endtask
  task automatic pulse_wrdi(); wrdi = 1; step(); wrdi = 0; endtask

  // issue a status write and raise chip select; returns after the start edge
  task automatic sr_issue(logic [7:0] d);
    cs_n = 0; req = 1; wdata = d;
    step();
    req = 0; cs_n = 1;
    step();
  endtask

  task automatic sr_full(logic [7:0] d, logic [7:0] exp_after, string rid);
    sr_issue(d);
    expect_item(0, 8'hFF, "R2");
    step(W - 1);
    expect_item(0, 8'hFF, rid);
    step();
    expect_item(0, exp_after, rid);
  endtask

  task automatic chk_addr(logic [AW-1:0] a, logic e, string rid);
    addr = a; #1;
    expect_item(1, {7'd0, e}, rid);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step();
    expect_item(0, 8'h00, "R1");
    expect_item(2, 8'h00, "R5");
    chk_addr(14'h3FFF, 1'b0, "R3");

    pulse_wren();
    expect_item(0, 8'h02, "R4");
    expect_item(2, 8'h01, "R5");
    wp_n = 0;
    pulse_wrdi();
    expect_item(0, 8'h00, "R4");
    wp_n = 1;
    wren = 1; wrdi = 1; step(); wren = 0; wrdi = 0;
    expect_item(0, 8'h00, "R4");

    // not enabled: request dropped
    sr_issue(8'h0C);
    expect_item(0, 8'h00, "R6");
    step(W);
    expect_item(0, 8'h00, "R6");

    // masked bits, exact commit timing, latch cleared
    pulse_wren();
    sr_full(8'h7F, 8'h0C, "R7");
    expect_item(0, 8'h0C, "R9");
    chk_addr(14'h0000, 1'b1, "R3");

    pulse_wren();
    sr_full(8'h04, 8'h04, "R7");
    chk_addr(14'h2FFF, 1'b0, "R3");
    chk_addr(14'h3000, 1'b1, "R3");

    pulse_wren();
    sr_full(8'h08, 8'h08, "R7");
    chk_addr(14'h1FFF, 1'b0, "R3");
    chk_addr(14'h2000, 1'b1, "R3");

    pulse_wren();
    sr_full(8'h80, 8'h80, "R7");
    chk_addr(14'h3FFF, 1'b0, "R3");

    // hardware protection
    pulse_wren();
    expect_item(0, 8'h82, "R4");
    wp_n = 0; #1;
    expect_item(2, 8'h00, "R5");
    sr_issue(8'h8C);
    expect_item(0, 8'h82, "R6");

    // cancel before chip select rises
    wp_n = 1;
    cs_n = 0; req = 1; wdata = 8'h8C;
    step();
    req = 0; wp_n = 0;
    step();
    cs_n = 1;
    step();
    expect_item(0, 8'h82, "R8");
    step(W);
    expect_item(0, 8'h82, "R8");

    // pin has no effect once started
    wp_n = 1;
    sr_issue(8'h0C);
    wp_n = 0;
    expect_item(0, 8'hFF, "R2");
    step(W);
    expect_item(0, 8'h0C, "R8");
    wp_n = 1;

    // external busy: request dropped, latch cleared at end
    pulse_wren();
    expect_item(0, 8'h0E, "R4");
    busy = 1; #1;
    expect_item(0, 8'hFF, "R2");
    expect_item(2, 8'h00, "R5");
    sr_issue(8'h00);
    step();
    busy = 0;
    step();
    expect_item(0, 8'h0C, "R9");
    step();
    expect_item(0, 8'h0C, "R10");
    step(W);
    expect_item(0, 8'h0C, "R10");

    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule